// File: doc/BRIEF.md
# Transmit Word Buffer with Release Control

This block sits between a host command port and a serial line transmitter. It stores up to 32 words of 32 bits and decides when those words are released to the downstream serializer. The host drives a single parallel command strobe with an 8-bit opcode and a 32-bit data field. Three operations exist: append one word, empty the buffer, and open a send session. The block reports empty, half-full and full status flags.

Words leave the buffer through a valid/ready pop handshake, head word first. A mode input picks one of two release policies. In automatic mode, any write command opens a send session. In held mode, words stay in the buffer until the host issues a start command. A session lasts until the buffer is empty and the serializer reports that it is idle. Words written while a session is open go out in that same session.

Top module: `txWordBuf`

## Requirements
- R1: Words are delivered on `popData` in the order they were accepted. While `popValid` is 1, `popData` equals the oldest stored word.
- R2: `isEmpty` is 1 exactly when no words are stored. `isFull` is 1 exactly when 32 words are stored. `popValid` is never 1 while the buffer is empty.
- R3: A write command that arrives while `isFull` is 1 is discarded and the stored contents do not change. Once a word has been popped, writes are accepted again.
- R4: `isHalf` is 0 whenever fewer than 16 words are stored and 1 whenever 16 or more are stored.
- R5: A clear command (opcode 0x11) leaves the buffer empty after the next clock edge. It takes precedence over a pop or a write in the same cycle.
- R6: With `autoSend` at 1, a write command (opcode 0x0E) sets `sessionActive` at the following edge. The written word is then offered on `popValid` in the cycle after that command.
- R7: With `autoSend` at 0, a start command (opcode 0x12) sets `sessionActive` at the following edge. During the session, `popValid` is 1 whenever words are stored, including words written after the start.
- R8: An open session closes at the edge where the buffer is empty and `serIdle` is 1, unless a start (or, in automatic mode, a write) arrives in that same cycle. In held mode, words written after the session closes keep `popValid` at 0 until the next start.
- R9: A command with any opcode other than 0x0E, 0x11 or 0x12 changes neither the stored words, the flags nor the session state.
- R10: When a write is accepted and a word is popped in the same cycle, the stored count stays the same.
- R11: After reset, `isEmpty` is 1, `isHalf`, `isFull`, `popValid` and `sessionActive` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| autoSend | input | 1 | Release mode: 1 automatic, 0 held until start |
| cmdValid | input | 1 | Command strobe, one command per cycle |
| cmdOp | input | 8 | Opcode: 0x0E write, 0x11 clear, 0x12 start |
| cmdData | input | 32 | Word appended by a write command |
| popValid | output | 1 | Head word offered to the serializer |
| popData | output | 32 | Head word |
| popReady | input | 1 | Serializer takes the head word when 1 with popValid |
| serIdle | input | 1 | Serializer has finished shifting its last word |
| isEmpty | output | 1 | No words stored |
| isHalf | output | 1 | At least 16 words stored |
| isFull | output | 1 | All 32 positions occupied |
| sessionActive | output | 1 | A send session is open |

## Verification
The bench fills the buffer past capacity. A design that wrapped its write pointer would overwrite the head word and deliver it out of order. A clear command is aimed at a cycle that also pops and writes, and a design that let the pop or write win would leave a word behind. In held mode the bench writes words just before and just after a session closes. A design that closes too early would strand words, and one that never closes would release the later words without a start. Writes and pops are also made to coincide at the full, empty and 15/16 boundaries, where an off-by-one shows up directly in the flags.

// File: rtl/txWordBufPkg.sv
package txWordBufPkg;
  localparam logic [7:0] OP_WRITE = 8'h0E;
  localparam logic [7:0] OP_CLEAR = 8'h11;
  localparam logic [7:0] OP_START = 8'h12;

  typedef struct packed {
    logic push;
    logic pop;
    logic clear;
  } bufStrobes_t;
endpackage

// File: rtl/txWordBufData.sv
module txWordBufData
  import txWordBufPkg::*;
#(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  bufStrobes_t       strobes,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] headData,
  output logic              isEmpty,
  output logic              isHalf,
  output logic              isFull
);
  localparam int PTR_W = $clog2(DEPTH);
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(DEPTH);
  localparam logic [CNT_W-1:0] CNT_HALF = CNT_W'(DEPTH / 2);
  localparam logic [PTR_W-1:0] PTR_LAST = PTR_W'(DEPTH - 1);

  logic [DATA_W-1:0] store [DEPTH];
  logic [PTR_W-1:0]  rdPtr;
  logic [PTR_W-1:0]  wrPtr;
  logic [CNT_W-1:0]  count;

  // the pointers wrap explicitly, so DEPTH does not have to be a power of two
  function automatic logic [PTR_W-1:0] nextPtr(input logic [PTR_W-1:0] p);
    return (p == PTR_LAST) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (strobes.push && !strobes.clear) begin
      store[wrPtr] <= wrData;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN || strobes.clear) begin
      rdPtr <= '0;
      wrPtr <= '0;
      count <= '0;
    end else begin
      if (strobes.push) wrPtr <= nextPtr(wrPtr);
      if (strobes.pop)  rdPtr <= nextPtr(rdPtr);
      case ({strobes.push, strobes.pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  assign headData = store[rdPtr];
  assign isEmpty  = (count == '0);
  assign isFull   = (count == CNT_FULL);
  assign isHalf   = (count >= CNT_HALF);
endmodule

// File: rtl/txWordBufCtrl.sv
module txWordBufCtrl
  import txWordBufPkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        autoSend,
  input  logic        cmdValid,
  input  logic [7:0]  cmdOp,
  input  logic        popReady,
  input  logic        serIdle,
  input  logic        isEmpty,
  input  logic        isFull,
  output logic        popValid,
  output logic        sessionActive,
  output bufStrobes_t strobes
);
  logic wrCmd;
  logic clrCmd;
  logic startCmd;
  logic sessOpen;
  logic sessClose;

  assign wrCmd    = cmdValid && (cmdOp == OP_WRITE);
  assign clrCmd   = cmdValid && (cmdOp == OP_CLEAR);
  assign startCmd = cmdValid && (cmdOp == OP_START);

  assign popValid = sessionActive && !isEmpty;

  always_comb begin
    strobes       = '0;
    strobes.clear = clrCmd;
    strobes.push  = wrCmd && !isFull && !clrCmd;
    strobes.pop   = popValid && popReady && !clrCmd;
  end

  // opening wins over closing in the same cycle
  assign sessOpen  = startCmd || (wrCmd && autoSend);
  assign sessClose = sessionActive && isEmpty && serIdle;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      sessionActive <= 1'b0;
    end else if (sessOpen) begin
      sessionActive <= 1'b1;
    end else if (sessClose) begin
      sessionActive <= 1'b0;
    end
  end
endmodule

// File: rtl/txWordBuf.sv
module txWordBuf
  import txWordBufPkg::*;
#(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              autoSend,
  input  logic              cmdValid,
  input  logic [7:0]        cmdOp,
  input  logic [DATA_W-1:0] cmdData,
  output logic              popValid,
  output logic [DATA_W-1:0] popData,
  input  logic              popReady,
  input  logic              serIdle,
  output logic              isEmpty,
  output logic              isHalf,
  output logic              isFull,
  output logic              sessionActive
);
  bufStrobes_t strobes;

  txWordBufCtrl ctrl_i (
    .clk          (clk),
    .rstN         (rstN),
    .autoSend     (autoSend),
    .cmdValid     (cmdValid),
    .cmdOp        (cmdOp),
    .popReady     (popReady),
    .serIdle      (serIdle),
    .isEmpty      (isEmpty),
    .isFull       (isFull),
    .popValid     (popValid),
    .sessionActive(sessionActive),
    .strobes      (strobes)
  );

  txWordBufData #(.DATA_W(DATA_W), .DEPTH(DEPTH)) data_i (
    .clk     (clk),
    .rstN    (rstN),
    .strobes (strobes),
    .wrData  (cmdData),
    .headData(popData),
    .isEmpty (isEmpty),
    .isHalf  (isHalf),
    .isFull  (isFull)
  );
endmodule

// File: rtl/txWordBufChk.sv
module txWordBufChk
  import txWordBufPkg::*;
(
  input logic       clk,
  input logic       rstN,
  input logic       autoSend,
  input logic       cmdValid,
  input logic [7:0] cmdOp,
  input logic       popValid,
  input logic       popReady,
  input logic       serIdle,
  input logic       isEmpty,
  input logic       isHalf,
  input logic       isFull,
  input logic       sessionActive
);
  logic wr;
  logic clr;
  logic st;
  logic other;
  assign wr    = cmdValid && cmdOp == OP_WRITE;
  assign clr   = cmdValid && cmdOp == OP_CLEAR;
  assign st    = cmdValid && cmdOp == OP_START;
  assign other = cmdValid && !wr && !clr && !st;

  assert_no_pop_when_empty_R2: assert property (@(posedge clk) disable iff (!rstN)
    isEmpty |-> !popValid);
  assert_valid_needs_session_R7: assert property (@(posedge clk) disable iff (!rstN)
    popValid |-> sessionActive);
  assert_drop_when_full_R3: assert property (@(posedge clk) disable iff (!rstN)
    (isFull && wr && !(popValid && popReady)) |=> isFull);
  assert_full_implies_half_R4: assert property (@(posedge clk) disable iff (!rstN)
    isFull |-> isHalf);
  assert_clear_empties_R5: assert property (@(posedge clk) disable iff (!rstN)
    clr |=> isEmpty);
  assert_auto_opens_R6: assert property (@(posedge clk) disable iff (!rstN)
    (autoSend && wr) |=> sessionActive);
  assert_session_closes_R8: assert property (@(posedge clk) disable iff (!rstN)
    (sessionActive && isEmpty && serIdle && !st && !(wr && autoSend)) |=> !sessionActive);
  assert_unknown_op_R9: assert property (@(posedge clk) disable iff (!rstN)
    (other && !(popValid && popReady)) |=> $stable({isEmpty, isHalf, isFull}));
endmodule

bind txWordBuf txWordBufChk chk_i (
  .clk          (clk),
  .rstN         (rstN),
  .autoSend     (autoSend),
  .cmdValid     (cmdValid),
  .cmdOp        (cmdOp),
  .popValid     (popValid),
  .popReady     (popReady),
  .serIdle      (serIdle),
  .isEmpty      (isEmpty),
  .isHalf       (isHalf),
  .isFull       (isFull),
  .sessionActive(sessionActive)
);

// File: tb/txWordBuf_tb_top.sv
module txWordBuf_tb_top;
  localparam int DEPTH = 32;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        autoSend = 1'b0;
  logic        cmdValid = 1'b0;
  logic [7:0]  cmdOp = 8'h00;
  logic [31:0] cmdData = '0;
  logic        popReady = 1'b0;
  logic        serIdle = 1'b1;
  logic        popValid;
  logic [31:0] popData;
  logic        isEmpty;
  logic        isHalf;
  logic        isFull;
  logic        sessionActive;

  int testsRun = 0;
  int testsFailed = 0;
  bit finished = 1'b0;

  logic [31:0] mq[$];
  bit          mSess = 1'b0;

  always #10 clk = ~clk;

  txWordBuf dut_i (
    .clk(clk), .rstN(rstN), .autoSend(autoSend), .cmdValid(cmdValid),
    .cmdOp(cmdOp), .cmdData(cmdData), .popValid(popValid), .popData(popData),
    .popReady(popReady), .serIdle(serIdle), .isEmpty(isEmpty), .isHalf(isHalf),
    .isFull(isFull), .sessionActive(sessionActive)
  );

  task automatic check(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
    testsRun++;
    if (!ok) begin
      testsFailed++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic bit mValid();
    return mSess && mq.size() != 0;
  endfunction

  task automatic compareAll();
    check(popValid == mValid(), "R7 popValid", 32'(popValid), 32'(mValid()));
    if (mValid())
      check(popData == mq[0], "R1 popData", popData, mq[0]);
    check(isEmpty == (mq.size() == 0), "R2 isEmpty", 32'(isEmpty), 32'(mq.size() == 0));
    check(isFull == (mq.size() == DEPTH), "R2 isFull", 32'(isFull), 32'(mq.size() == DEPTH));
    check(isHalf == (mq.size() >= DEPTH/2), "R4 isHalf", 32'(isHalf), 32'(mq.size() >= DEPTH/2));
    check(sessionActive == mSess, "R8 sessionActive", 32'(sessionActive), 32'(mSess));
  endtask

  // one clock step: drive at negedge, update the model at the edge, compare at next negedge
  task automatic step(input bit v, input logic [7:0] op, input logic [31:0] d,
                      input bit rdy, input bit idle);
    bit wr, clr, st, popF, pushF, nextSess;
    cmdValid = v; cmdOp = op; cmdData = d; popReady = rdy; serIdle = idle;
    wr = v && op == 8'h0E; clr = v && op == 8'h11; st = v && op == 8'h12;
    popF  = mValid() && rdy && !clr;
    pushF = wr && mq.size() < DEPTH && !clr;
    if (st || (wr && autoSend)) nextSess = 1'b1;
    else if (mSess && mq.size() == 0 && idle) nextSess = 1'b0;
    else nextSess = mSess;
    @(posedge clk);
    if (clr) mq.delete();
    else begin
      if (popF) void'(mq.pop_front());
      if (pushF) mq.push_back(d);
    end
    mSess = nextSess;
    @(negedge clk);
    cmdValid = 1'b0;
    compareAll();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      testsFailed++;
      testsRun++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
      $finish;
    end
  end

  initial begin
    int sizeBefore;
    void'($urandom(32'h5EED_1234));
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    // R11 reset state
    check(isEmpty && !isHalf && !isFull && !popValid && !sessionActive, "R11 reset",
          {27'b0, isEmpty, isHalf, isFull, popValid, sessionActive}, 32'h10);

    // held mode: words stay until start (R8)
    autoSend = 1'b0;
    for (int i = 0; i < 3; i++) step(1, 8'h0E, 32'hA000_0000 + i, 1, 1);
    check(!popValid, "R8 held before start", 32'(popValid), 0);
    step(1, 8'h12, 0, 0, 0);
    check(popValid && popData == 32'hA000_0000, "R7 start releases head", popData, 32'hA000_0000);
    // write during session also goes out (R7), pop with it (R10)
    step(1, 8'h0E, 32'hB000_0001, 1, 0);
    check(mq.size() == 3 && !isEmpty, "R10 push and pop same cycle", 32'(isEmpty), 0);
    for (int i = 0; i < 3; i++) step(0, 0, 0, 1, 0);
    check(isEmpty && sessionActive, "R8 session waits for idle", 32'(sessionActive), 1);
    step(0, 0, 0, 0, 1);
    check(!sessionActive, "R8 session closes", 32'(sessionActive), 0);
    step(1, 8'h0E, 32'hC0DE_0000, 0, 1);
    check(!popValid, "R8 word held after close", 32'(popValid), 0);

    // fill to full, extra write dropped (R3), half flag boundary (R4)
    for (int i = 0; i < 14; i++) step(1, 8'h0E, 32'h1000 + i, 0, 1);
    check(!isHalf, "R4 half at 15", 32'(isHalf), 0);
    step(1, 8'h0E, 32'h2000, 0, 1);
    check(isHalf, "R4 half at 16", 32'(isHalf), 1);
    for (int i = 0; i < 16; i++) step(1, 8'h0E, 32'h3000 + i, 0, 1);
    check(isFull, "R2 full at 32", 32'(isFull), 1);
    step(1, 8'h0E, 32'hDEAD_BEEF, 0, 1);
    check(isFull && mq[DEPTH-1] == 32'h300F, "R3 write dropped when full", 32'(isFull), 1);
    // unknown opcodes (R9)
    sizeBefore = mq.size();
    step(1, 8'h13, 0, 1, 1);
    step(1, 8'h0F, 0, 1, 1);
    check(!sessionActive && isFull && mq.size() == sizeBefore, "R9 unknown op no effect",
          32'(sessionActive), 0);
    step(1, 8'h12, 0, 0, 0);
    step(0, 0, 0, 1, 0);
    step(1, 8'h0E, 32'h4444_4444, 0, 0);
    check(isFull, "R3 write accepted after pop", 32'(isFull), 1);
    // clear beats pop and write (R5)
    step(1, 8'h11, 0, 1, 0);
    check(isEmpty && !popValid, "R5 clear empties", 32'(isEmpty), 1);

    // automatic mode (R6)
    autoSend = 1'b1;
    step(0, 0, 0, 0, 1);
    step(1, 8'h0E, 32'h6666_0001, 0, 0);
    check(popValid && sessionActive && popData == 32'h6666_0001, "R6 auto release",
          popData, 32'h6666_0001);

    // random phase
    for (int phase = 0; phase < 8; phase++) begin
      autoSend = phase[0];
      for (int c = 0; c < 1500; c++) begin
        int r = $urandom_range(0, 99);
        logic [7:0] op;
        if (r < 55) op = 8'h0E;
        else if (r < 58) op = 8'h11;
        else if (r < 66) op = 8'h12;
        else if (r < 70) op = 8'($urandom);
        else op = 8'h00;
        step(r < 70, op, $urandom, ($urandom_range(0, 99) < (phase < 4 ? 60 : 30)),
             ($urandom_range(0, 3) == 0));
      end
    end

    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end
endmodule